// File: doc/BRIEF.md
# Indirect register file addressing unit

This unit sits in front of the data register file of a small banked microcontroller and turns each instruction's operand into the address the file will actually use. An operand field is normally combined with two bank-select bits to form a 9-bit direct address. One operand value is reserved: when the field is zero, the access goes through a virtual indirection register. That register has no storage. The real target is then taken from an 8-bit pointer register, with a separate pointer-bank bit placed above it.

If the pointer itself points back at the indirection register, the access is meaningless. The indirection register counts as selected when the low seven pointer bits are zero, in any bank. In that case the unit tells the register file to return zero for a read and blocks the write. The flag logic of the instruction is not affected. All controls are registered once, so the register file sees them one cycle after the operand is presented. The pointer is an ordinary register, and the value it holds in a given cycle is the one used for that cycle's indirect access.

Top module: `ind_addr_unit`

## Requirements
- R1: While `rst_n` is low, and at the first check after reset, `eff_addr`, `indirect`, `rd_zero` and `wr_gate` are all 0.
- R2: If `op_addr` is nonzero, the cycle after it is presented `eff_addr` = {`bank_bits`, `op_addr`} (bank bits in bits 8:7), `indirect` = 0, `rd_zero` = 0 and `wr_gate` = `wr_req`.
- R3: If `op_addr` is zero, the cycle after it is presented `eff_addr` = {`ptr_bank`, `ptr`} (pointer-bank bit in bit 8) and `indirect` = 1, whatever `bank_bits` holds.
- R4: An indirect access whose pointer has bits 6:0 all zero, in any bank, is a self-selection. For it `rd_zero` = `rd_req`. For every other access `rd_zero` = 0.
- R5: On a self-selection `wr_gate` = 0 even when `wr_req` = 1. For any other indirect access `wr_gate` = `wr_req`.
- R6: Every output reflects the inputs sampled at the preceding rising clock edge, exactly one cycle of latency. A pointer stepped from 05h to 06h between two indirect accesses yields `eff_addr` 005h and then 006h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_addr | input | 7 | Operand address field of the instruction |
| bank_bits | input | 2 | Bank select for direct accesses |
| ptr | input | 8 | Current pointer register value |
| ptr_bank | input | 1 | Bank bit placed above the pointer |
| rd_req | input | 1 | Instruction reads its operand |
| wr_req | input | 1 | Instruction writes its operand |
| eff_addr | output | 9 | Effective register file address |
| indirect | output | 1 | Access went through the pointer |
| rd_zero | output | 1 | Register file must return 00h |
| wr_gate | output | 1 | Write enable to the register file |

## Verification
The bench aims at the edges of the self-selection test. Pointers 00h, 80h and 00h with the pointer-bank bit set must all be trapped, so a design that compared all nine bits would let writes through in the upper banks. A pointer such as 01h or 40h must still write, so a design that tested too few bits would drop legal writes. A direct operand in a nonzero bank must keep its bank, and an indirect operand must ignore it. The pointer-step pair checks that the pointer is not delayed or taken early by one cycle.

// File: rtl/ind_addr_unit.sv
module ind_addr_unit #(
  parameter int DIR_W  = 7,
  parameter int BANK_W = 2,
  parameter int PTR_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DIR_W-1:0]          op_addr,
  input  logic [BANK_W-1:0]         bank_bits,
  input  logic [PTR_W-1:0]          ptr,
  input  logic                      ptr_bank,
  input  logic                      rd_req,
  input  logic                      wr_req,
  output logic [DIR_W+BANK_W-1:0]   eff_addr,
  output logic                      indirect,
  output logic                      rd_zero,
  output logic                      wr_gate
);
  localparam int EA_W = DIR_W + BANK_W;

  logic            via_ptr;
  logic            self_sel;
  logic [EA_W-1:0] ea_next;

  assign via_ptr  = (op_addr == '0);
  assign self_sel = via_ptr && (ptr[DIR_W-1:0] == '0);
  assign ea_next  = via_ptr ? EA_W'({ptr_bank, ptr}) : {bank_bits, op_addr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_addr <= '0;
      indirect <= 1'b0;
      rd_zero  <= 1'b0;
      wr_gate  <= 1'b0;
    end else begin
      eff_addr <= ea_next;
      indirect <= via_ptr;
      rd_zero  <= rd_req && self_sel;
      wr_gate  <= wr_req && !self_sel;
    end
  end

  // R4: a zero-read only ever comes from an indirect access
  a_r4_zero_only_indirect: assert property (@(posedge clk) disable iff (!rst_n)
    rd_zero |-> indirect);

  // R4: a zero-read always points at offset zero of some bank
  a_r4_zero_at_offset0: assert property (@(posedge clk) disable iff (!rst_n)
    rd_zero |-> (eff_addr[DIR_W-1:0] == '0));

  // R5: no write reaches offset zero through the pointer
  a_r5_no_self_write: assert property (@(posedge clk) disable iff (!rst_n)
    (indirect && eff_addr[DIR_W-1:0] == '0) |-> !wr_gate);

  // R2: a direct result never lands on offset zero
  a_r2_direct_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    !indirect |-> (eff_addr[DIR_W-1:0] != '0) || (eff_addr == '0 && !wr_gate && !rd_zero));
endmodule

// File: tb/sim_ind_addr_unit.sv
module sim_ind_addr_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] op_addr = '0;
  logic [1:0] bank_bits = '0;
  logic [7:0] ptr = '0;
  logic       ptr_bank = 1'b0;
  logic       rd_req = 1'b0;
  logic       wr_req = 1'b0;
  logic [8:0] eff_addr;
  logic       indirect, rd_zero, wr_gate;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  ind_addr_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_addr(op_addr), .bank_bits(bank_bits),
    .ptr(ptr), .ptr_bank(ptr_bank), .rd_req(rd_req), .wr_req(wr_req),
    .eff_addr(eff_addr), .indirect(indirect), .rd_zero(rd_zero), .wr_gate(wr_gate)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int e_ea, e_ind, e_rz, e_wg;

  task automatic model(input int oa, input int bk, input int p, input int pb,
                       input int rd, input int wr);
    bit selfsel;
    if (oa == 0) begin
      e_ea = pb * 256 + p;
      e_ind = 1;
      selfsel = (p % 128) == 0;
    end else begin
      e_ea = bk * 128 + oa;
      e_ind = 0;
      selfsel = 0;
    end
    e_rz = (rd != 0 && selfsel) ? 1 : 0;
    e_wg = (wr != 0 && !selfsel) ? 1 : 0;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (int'(eff_addr) != e_ea || int'(indirect) != e_ind ||
        int'(rd_zero) != e_rz || int'(wr_gate) != e_wg) begin
      fails++;
      $display("FAIL %s: got ea=%03h ind=%0d rz=%0d wg=%0d expected ea=%03h ind=%0d rz=%0d wg=%0d",
               tag, eff_addr, indirect, rd_zero, wr_gate, e_ea, e_ind, e_rz, e_wg);
    end
  endtask

  // drive on falling edge, captured at rising edge, checked at next falling edge
  task automatic apply(input int oa, input int bk, input int p, input int pb,
                       input int rd, input int wr, input string tag);
    string t;
    op_addr = 7'(oa); bank_bits = 2'(bk); ptr = 8'(p); ptr_bank = 1'(pb);
    rd_req = 1'(rd); wr_req = 1'(wr);
    model(oa, bk, p, pb, rd, wr);
    @(negedge clk);
    t = tag;
    if (t == "") t = (oa != 0) ? "R2" : (((p % 128) == 0) ? "R4/R5" : "R3");
    compare(t);
  endtask

  initial begin
    @(negedge clk);
    op_addr = 7'h12; wr_req = 1'b1; rd_req = 1'b1;
    @(negedge clk);
    e_ea = 0; e_ind = 0; e_rz = 0; e_wg = 0;
    compare("R1 in reset");
    rst_n = 1'b1;
    compare("R1 after reset");

    apply(7'h25, 0, 8'h00, 0, 1, 1, "R2 bank0");
    apply(7'h7f, 3, 8'h55, 1, 0, 1, "R2 bank3");
    apply(7'h01, 2, 8'h00, 0, 1, 0, "R2 bank2");
    apply(0, 3, 8'h05, 0, 1, 0, "R3 bank ignored");
    apply(0, 0, 8'hff, 1, 0, 1, "R3 top");
    apply(0, 1, 8'h00, 0, 1, 1, "R4 R5 ptr 000");
    apply(0, 2, 8'h80, 0, 1, 1, "R4 R5 ptr 080");
    apply(0, 0, 8'h00, 1, 1, 1, "R4 R5 ptr 100");
    apply(0, 0, 8'h80, 1, 0, 1, "R5 ptr 180");
    apply(0, 0, 8'h01, 0, 1, 1, "R4 R5 ptr 001");
    apply(0, 0, 8'h40, 1, 1, 1, "R5 ptr 140");
    apply(0, 0, 8'h05, 0, 1, 0, "R6 ptr 05");
    apply(0, 0, 8'h06, 0, 1, 0, "R6 ptr 06");
    apply(7'h05, 0, 8'h06, 0, 1, 0, "R6 back to direct");

    for (int i = 0; i < 400; i++) begin
      int oa;
      oa = ($urandom % 3 == 0) ? 0 : int'($urandom % 128);
      apply(oa, int'($urandom % 4), ($urandom % 4 == 0) ? int'(($urandom % 2) * 128)
            : int'($urandom % 256), int'($urandom % 2), int'($urandom % 2),
            int'($urandom % 2), "");
    end

    // R1: reset in mid-run clears everything again
    rst_n = 1'b0;
    #1;
    e_ea = 0; e_ind = 0; e_rz = 0; e_wg = 0;
    compare("R1 async reset");
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule